// File: doc/BRIEF.md
# Flash Command Decoder

This block is the device side of a byte-wide, block-erasable flash array. The array itself is a small register-backed memory. Every byte written on the bus is taken as a command, or as the operand of the command before it. Reads return one of three things, chosen by the current read mode: array contents, the two identifier bytes, or a status byte. A status byte reports readiness and keeps a sticky record of erase and program errors.

Erase and program are not timed by cell physics. A counter, loaded from the `busyCycles` input when an operation starts, sets how long the device stays busy. A program can only turn ones into zeros. An erase sets a whole block back to all ones. Two inject inputs force an operation to fail, so that host software can exercise its error paths.

Top module: `flashcmd_top`

## Requirements
- R1: After reset the read mode is array, every array byte reads 0xFF, and the status byte reads 0x80.
- R2: Writing 0x90 selects identifier reads. Offset 0 returns the high identifier byte. The low byte sits at offset 2 when the high byte is 0xB0, and at offset 1 otherwise. Every other offset returns 0x00.
- R3: Writing 0xFF selects array reads, which return the stored byte at the bus address.
- R4: Writing 0x70 selects status reads. In the status byte, bit 7 is ready, bit 5 is erase error, bit 4 is program error, and all other bits are 0.
- R5: Writing 0x50 clears both error bits and leaves the read mode unchanged. Error bits otherwise stay set once set.
- R6: Writing 0x20 and then 0xD0 erases the block that holds the address of the 0xD0 write. A block is 2^BLOCK_W bytes, selected by the address bits above BLOCK_W. Every byte of that block then reads 0xFF, and other blocks keep their contents.
- R7: If the write after 0x20 is not 0xD0, the erase is abandoned, both error bits are set, and the array is left unchanged.
- R8: Writing 0x40 and then a data byte replaces the byte at the data write's address with the old value AND the data.
- R9: The write that starts an erase or program begins a busy period. The device stays busy for busyCycles+1 further clock edges. While busy, status bit 7 reads 0.
- R10: Writes made while busy are ignored, including mode commands.
- R11: After 0x20 or 0x40, reads return the status byte until another mode command is written.
- R12: When injEraseErr is high on the cycle an erase starts, bit 5 is set and the block is left unchanged. When injProgErr is high on the cycle a program starts, bit 4 is set and the byte is left unchanged.
- R13: A command byte outside the recognised set is ignored, and the read mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| wrData | input | 8 | Command or operand byte |
| busyCycles | input | CNT_W | Busy length loaded when an operation starts |
| injEraseErr | input | 1 | Forces the erase that starts this cycle to fail |
| injProgErr | input | 1 | Forces the program that starts this cycle to fail |
| rdData | output | 8 | Read data, combinational from addr and the read mode |

## Verification
Byte program is tried three ways. The first is onto an erased cell. The second is onto a cell that already holds data, which separates AND from overwrite. The third runs with failure injected, which separates the injected failure from a normal commit. Erase is tried on a block next to one holding data, to show the block boundary, and again with failure injected. The erase sequence is also broken with a non-confirm byte, which marks a sequence error apart from a real erase. Identifier reads go to two instances with different high bytes, which tells the two placements of the low byte apart. A command written during the busy period, followed by a read of the mode that results, shows that busy writes are ignored. One status read on each cycle of a busy period pins its exact length.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_IDENT = 8'h90;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLEAR_STAT = 8'h50;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_PROGRAM    = 8'h40;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } readMode_e;

  typedef struct packed {
    logic clrErr;
    logic seqErr;
    logic commitErase;
    logic commitProg;
    logic failInj;
  } dpStrobe_t;

endpackage

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [CNT_W-1:0]  busyCycles,
  input  logic              injEraseErr,
  input  logic              injProgErr,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output readMode_e         mode,
  output logic              busy
);

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_ERASE_WAIT = 2'd1,
    ST_PROG_WAIT  = 2'd2,
    ST_BUSY       = 2'd3
  } seqState_e;

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic             opIsErase;
  logic             injLatched;
  logic             cntDone;

  assign cntDone = (cnt == '0);
  assign busy    = (state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      mode       <= RD_ARRAY;
      cnt        <= '0;
      opIsErase  <= 1'b0;
      injLatched <= 1'b0;
      opAddr     <= '0;
      opData     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (wrEn) begin
          case (wrData)
            OP_READ_ARRAY: mode <= RD_ARRAY;
            OP_READ_IDENT: mode <= RD_IDENT;
            OP_READ_STAT:  mode <= RD_STATUS;
            OP_ERASE: begin
              state <= ST_ERASE_WAIT;
              mode  <= RD_STATUS;
            end
            OP_PROGRAM: begin
              state <= ST_PROG_WAIT;
              mode  <= RD_STATUS;
            end
            default: ;
          endcase
        end
        ST_ERASE_WAIT: if (wrEn) begin
          if (wrData == OP_CONFIRM) begin
            state      <= ST_BUSY;
            opIsErase  <= 1'b1;
            opAddr     <= addr;
            cnt        <= busyCycles;
            injLatched <= injEraseErr;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_PROG_WAIT: if (wrEn) begin
          state      <= ST_BUSY;
          opIsErase  <= 1'b0;
          opAddr     <= addr;
          opData     <= wrData;
          cnt        <= busyCycles;
          injLatched <= injProgErr;
        end
        ST_BUSY: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb             = '0;
    strb.clrErr      = (state == ST_IDLE) && wrEn && (wrData == OP_CLEAR_STAT);
    strb.seqErr      = (state == ST_ERASE_WAIT) && wrEn && (wrData != OP_CONFIRM);
    strb.commitErase = busy && cntDone && opIsErase;
    strb.commitProg  = busy && cntDone && !opIsErase;
    strb.failInj     = injLatched;
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cntDone) |=> busy) else $error("busy ended early"); // R9

  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitErase || strb.commitProg) |=> !busy) else $error("busy after commit"); // R9

  AST_BUSY_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(mode)) else $error("mode changed while busy"); // R10

endmodule

// File: rtl/flashcmd_dp.sv
module flashcmd_dp
  import flashcmd_pkg::*;
#(
  parameter int         ADDR_W  = 6,
  parameter int         BLOCK_W = 4,
  parameter logic [7:0] ID_HI   = 8'h89,
  parameter logic [7:0] ID_LO   = 8'hA6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        opData,
  input  readMode_e         mode,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdData
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int NUM_BLK   = 1 << (ADDR_W - BLOCK_W);
  localparam int ID_LO_OFF = (ID_HI == 8'hB0) ? 2 : 1;

  logic [7:0]         mem [DEPTH];
  logic               errErase;
  logic               errProg;
  logic [NUM_BLK-1:0] blkHit;
  logic [7:0]         statusByte;
  logic [7:0]         progCell;

  for (genvar b = 0; b < NUM_BLK; b++) begin : gBlkHit
    assign blkHit[b] = (opAddr[ADDR_W-1:BLOCK_W] == (ADDR_W-BLOCK_W)'(b));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (strb.commitErase && !strb.failInj) begin
      for (int i = 0; i < DEPTH; i++)
        if (blkHit[i >> BLOCK_W]) mem[i] <= 8'hFF;
    end else if (strb.commitProg && !strb.failInj) begin
      mem[opAddr] <= mem[opAddr] & opData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errErase <= 1'b0;
      errProg  <= 1'b0;
    end else if (strb.clrErr) begin
      errErase <= 1'b0;
      errProg  <= 1'b0;
    end else if (strb.seqErr) begin
      errErase <= 1'b1;
      errProg  <= 1'b1;
    end else begin
      if (strb.commitErase && strb.failInj) errErase <= 1'b1;
      if (strb.commitProg && strb.failInj)  errProg  <= 1'b1;
    end
  end

  assign statusByte = {!busy, 1'b0, errErase, errProg, 4'b0000};
  assign progCell   = mem[opAddr];

  always_comb begin
    unique case (mode)
      RD_STATUS: rdData = statusByte;
      RD_IDENT: begin
        if (addr == '0)                        rdData = ID_HI;
        else if (addr == ADDR_W'(ID_LO_OFF))   rdData = ID_LO;
        else                                   rdData = 8'h00;
      end
      default: rdData = mem[addr];
    endcase
  end

  AST_ERASE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errErase && !strb.clrErr) |=> errErase) else $error("erase error lost"); // R5

  AST_PROG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errProg && !strb.clrErr) |=> errProg) else $error("program error lost"); // R5

  AST_SEQ_SETS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqErr |=> (errErase && errProg)) else $error("sequence error flags"); // R7

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitProg |=> ((progCell & ~$past(progCell)) == 8'h00)) else $error("program set a bit"); // R8

  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitErase && !strb.failInj) |=> (progCell == 8'hFF)) else $error("erase left zeros"); // R6

endmodule

// File: rtl/flashcmd_top.sv
module flashcmd_top
  import flashcmd_pkg::*;
#(
  parameter int         ADDR_W  = 6,
  parameter int         BLOCK_W = 4,
  parameter int         CNT_W   = 16,
  parameter logic [7:0] ID_HI   = 8'h89,
  parameter logic [7:0] ID_LO   = 8'hA6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [CNT_W-1:0]  busyCycles,
  input  logic              injEraseErr,
  input  logic              injProgErr,
  output logic [7:0]        rdData
);

  dpStrobe_t         strb;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  readMode_e         mode;
  logic              busy;

  flashcmd_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .busyCycles(busyCycles), .injEraseErr(injEraseErr), .injProgErr(injProgErr),
    .strb(strb), .opAddr(opAddr), .opData(opData), .mode(mode), .busy(busy)
  );

  flashcmd_dp #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .opData(opData),
    .mode(mode), .busy(busy), .addr(addr), .rdData(rdData)
  );

endmodule

// File: tb/flashcmd_top_test.sv
module flashcmd_top_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [15:0] busyCycles = 16'd3;
  logic       injEraseErr = 1'b0;
  logic       injProgErr = 1'b0;
  logic [7:0] rdData;
  logic [7:0] bigRd;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  logic [7:0] expQ[$];
  bit         selQ[$];
  string      tagQ[$];
  event       sampleEv;

  always #2 clk = ~clk;

  flashcmd_top uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .busyCycles(busyCycles), .injEraseErr(injEraseErr), .injProgErr(injProgErr),
    .rdData(rdData)
  );

  flashcmd_top #(.ID_HI(8'hB0), .ID_LO(8'hD4)) uutBig (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .busyCycles(busyCycles), .injEraseErr(injEraseErr), .injProgErr(injProgErr),
    .rdData(bigRd)
  );

  // monitor: pops one expectation per sample event
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        logic [7:0] e;
        logic [7:0] got;
        bit         s;
        string      t;
        e = expQ.pop_front();
        s = selQ.pop_front();
        t = tagQ.pop_front();
        got = s ? bigRd : rdData;
        nChecks++;
        if (got !== e) begin
          nFails++;
          $display("FAIL %s: actual %02h expected %02h", t, got, e);
        end
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t, input bit big = 1'b0);
    addr = a;
    #1;
    expQ.push_back(e); selQ.push_back(big); tagQ.push_back(t);
    -> sampleEv;
    @(negedge clk);
  endtask

  task automatic waitReady();
    for (int k = 0; k < 500; k++) begin
      #1;
      if (rdData[7]) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R9: watchdog expired, actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'd5, 8'hFF, "R1 array after reset");
    rd(6'd40, 8'hFF, "R1 array after reset hi");
    wr(6'd0, 8'h70);
    rd(6'd0, 8'h80, "R1 R4 status after reset");

    // R2 identifier, both placements
    wr(6'd0, 8'h90);
    rd(6'd0, 8'h89, "R2 id high");
    rd(6'd1, 8'hA6, "R2 id low at 1");
    rd(6'd2, 8'h00, "R2 id other offset");
    rd(6'd0, 8'hB0, "R2 big id high", 1'b1);
    rd(6'd1, 8'h00, "R2 big offset 1", 1'b1);
    rd(6'd2, 8'hD4, "R2 big id low at 2", 1'b1);

    // R13 unknown command keeps mode
    wr(6'd0, 8'h33);
    rd(6'd0, 8'h89, "R13 unknown command ignored");

    // R3 array mode
    wr(6'd0, 8'hFF);
    rd(6'd5, 8'hFF, "R3 array read");

    // R8 R9 R11 program, exact busy length with busyCycles=3
    wr(6'd0, 8'h40);
    rd(6'd9, 8'h80, "R11 status after program command");
    wr(6'd5, 8'hA5);
    rd(6'd5, 8'h00, "R9 busy edge0");
    rd(6'd5, 8'h00, "R9 busy edge1");
    rd(6'd5, 8'h00, "R9 busy edge2");
    rd(6'd5, 8'h00, "R9 busy edge3");
    rd(6'd5, 8'h80, "R9 ready edge4");
    wr(6'd0, 8'hFF);
    rd(6'd5, 8'hA5, "R8 program erased cell");
    wr(6'd0, 8'h40);
    wr(6'd5, 8'h3C);
    waitReady();
    wr(6'd0, 8'hFF);
    rd(6'd5, 8'h24, "R8 program ANDs old data");

    // R10 command during busy ignored
    wr(6'd0, 8'h40);
    wr(6'd6, 8'h0F);
    wr(6'd0, 8'hFF);
    waitReady();
    rd(6'd0, 8'h80, "R10 busy write ignored, still status");
    wr(6'd0, 8'hFF);
    rd(6'd6, 8'h0F, "R10 program completed");

    // R6 erase block 0, block 1 kept
    wr(6'd0, 8'h40);
    wr(6'd20, 8'h11);
    waitReady();
    wr(6'd3, 8'h20);
    rd(6'd3, 8'h80, "R11 status after erase command");
    wr(6'd3, 8'hD0);
    rd(6'd3, 8'h00, "R9 busy during erase");
    waitReady();
    rd(6'd0, 8'h80, "R6 erase ok status");
    wr(6'd0, 8'hFF);
    rd(6'd5, 8'hFF, "R6 erased byte 5");
    rd(6'd6, 8'hFF, "R6 erased byte 6");
    rd(6'd20, 8'h11, "R6 other block kept");

    // R7 broken erase sequence
    wr(6'd20, 8'h20);
    wr(6'd20, 8'h40);
    rd(6'd0, 8'hB0, "R7 sequence error flags");
    wr(6'd0, 8'hFF);
    rd(6'd20, 8'h11, "R7 array untouched");

    // R5 clear keeps mode, clears bits
    wr(6'd0, 8'h50);
    rd(6'd20, 8'h11, "R5 clear keeps array mode");
    wr(6'd0, 8'h70);
    rd(6'd0, 8'h80, "R5 errors cleared");

    // R12 injected program failure
    wr(6'd0, 8'h40);
    injProgErr = 1'b1;
    wr(6'd21, 8'h00);
    injProgErr = 1'b0;
    waitReady();
    rd(6'd0, 8'h90, "R12 program failure bit");
    wr(6'd0, 8'hFF);
    rd(6'd21, 8'hFF, "R12 failed program leaves cell");
    wr(6'd0, 8'h50);
    wr(6'd0, 8'h70);
    rd(6'd0, 8'h80, "R5 cleared after program failure");

    // R12 injected erase failure
    wr(6'd17, 8'h20);
    injEraseErr = 1'b1;
    wr(6'd17, 8'hD0);
    injEraseErr = 1'b0;
    waitReady();
    rd(6'd0, 8'hA0, "R12 erase failure bit");
    wr(6'd0, 8'hFF);
    rd(6'd20, 8'h11, "R12 failed erase leaves block");

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule